// File: doc/BRIEF.md
# Activation Normalize Quantize Pipeline

This block turns a stream of wide signed accumulator sums into signed 8-bit activations ready to be stored for the next layer. Each sum passes through three registered stages. The first is a rectifier that forces negative values to zero. The second applies fixed-point scaling: it multiplies by a gain, shifts right and adds an offset. The third performs affine requantization with an inverse scale and a zero point, and clamps the result into the int8 range.

Beside the data path, the block produces an absolute-error (L1) value between the scaled value and a target that travels with each sample. This loss leaves the block in the same cycle as the int8 result of the same sample.

A single downstream ready freezes the whole pipeline. While it is low, no input is taken and every stage keeps its contents, so no sample is dropped. The configuration inputs are expected to stay constant while samples are in flight.

Top module: `act_quant_pipe`

## Requirements
- R1: A negative input sample is treated as zero. A non-negative input sample enters the scaling stage unchanged.
- R2: The rectified value is multiplied by the 16-bit unsigned `cfg_gain` with a full 48-bit product, so no product bits are lost, even for gain 0xFFFF and input 0x7FFFFFFF.
- R3: The product is shifted right by `cfg_shift` bit positions (0..63). Then the signed 32-bit `cfg_bias` is added, and the result may be negative.
- R4: The scaled value saturates to the signed 32-bit range [-2^31, 2^31-1] when the bias addition exceeds it.
- R5: The int8 result is floor((scaled × cfg_qscale) / 256) + cfg_qzero. Here cfg_qscale is 16-bit unsigned with 8 fractional bits, and cfg_qzero is signed 8-bit. The division rounds toward minus infinity.
- R6: The int8 result is clamped to [-128, 127]. Values that land exactly on a bound pass unchanged.
- R7: With `out_ready` held high, `out_valid` rises exactly three clock edges after the edge that accepts a sample. Back-to-back samples leave back-to-back, in order, and idle input cycles appear as idle output cycles.
- R8: `out_loss` equals |scaled value − target| as a 33-bit unsigned number, where the target is the `in_target` sampled together with the same input. It is valid, with `out_loss_valid`, in the same cycle as the int8 result of that sample.
- R9: `in_ready` follows `out_ready`. While `out_ready` is low, `out_valid`, `out_data` and `out_loss` hold, and every accepted sample is eventually delivered once, in order.
- R10: After synchronous reset, `out_valid` and `out_loss_valid` are low, and `out_data` and `out_loss` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with in_valid |
| in_data | input | 32 | Signed accumulator sum |
| in_target | input | 32 | Signed target for the L1 loss of this sample |
| cfg_gain | input | 16 | Unsigned scaling gain |
| cfg_shift | input | 6 | Right shift applied to the product |
| cfg_bias | input | 32 | Signed offset added after the shift |
| cfg_qscale | input | 16 | Unsigned inverse quantization scale, 8 fractional bits |
| cfg_qzero | input | 8 | Signed quantization zero point |
| out_ready | input | 1 | Downstream can take a result |
| out_valid | output | 1 | int8 result valid |
| out_data | output | 8 | Signed int8 activation |
| out_loss_valid | output | 1 | Loss value valid |
| out_loss | output | 33 | Unsigned absolute error |

## Verification
The hardest case to reach from the ports is a stall that starts while all three stages hold different samples and an input is waiting at the boundary. If that case goes wrong, a sample can be dropped or duplicated inside the block without any port showing it directly. The stimulus streams samples back to back and drops `out_ready` in the middle of the stream. A scoreboard then confirms that every accepted sample comes out exactly once, in order.

The upper end of the scaling range is also hard to see through the int8 output, because the clamp hides it. The bench therefore uses a target of zero or of -2^31, which turns the loss output into a direct view of the full 32-bit scaled value.

// File: rtl/act_quant_pkg.sv
package act_quant_pkg;
  localparam int ACC_W_D   = 32;
  localparam int GAIN_W_D  = 16;
  localparam int SHIFT_W_D = 6;
  localparam int QS_W_D    = 16;
  localparam int QFRAC_D   = 8;
  localparam int QOUT_W_D  = 8;
  localparam int STAGES    = 3;
endpackage

// File: rtl/aq_relu.sv
module aq_relu #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                v_i,
  input  logic signed [W-1:0] d_i,
  input  logic signed [W-1:0] t_i,
  output logic                v_o,
  output logic signed [W-1:0] d_o,
  output logic signed [W-1:0] t_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      d_o <= '0;
      t_o <= '0;
    end else if (en) begin
      v_o <= v_i;
      d_o <= d_i[W-1] ? '0 : d_i;
      t_o <= t_i;
    end
  end
endmodule

// File: rtl/aq_norm.sv
module aq_norm #(
  parameter int W  = 32,
  parameter int GW = 16,
  parameter int SW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                v_i,
  input  logic signed [W-1:0] d_i,
  input  logic signed [W-1:0] t_i,
  input  logic [GW-1:0]       gain_i,
  input  logic [SW-1:0]       shift_i,
  input  logic signed [W-1:0] bias_i,
  output logic                v_o,
  output logic signed [W-1:0] n_o,
  output logic signed [W-1:0] t_o
);
  localparam int PW = W + GW;
  localparam int SUMW = PW + 2;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [PW-1:0]          prod;
  logic [PW-1:0]          shd;
  logic signed [SUMW-1:0] sum_w;
  logic [SUMW-W:0]        top;
  logic signed [W-1:0]    sat;

  always_comb begin
    prod  = {{GW{1'b0}}, d_i} * {{W{1'b0}}, gain_i};
    shd   = prod >> shift_i;
    sum_w = $signed({2'b00, shd}) + $signed({{(SUMW-W){bias_i[W-1]}}, bias_i});
    top   = sum_w[SUMW-1:W-1];
    if (top == '0 || top == '1) sat = sum_w[W-1:0];
    else                        sat = sum_w[SUMW-1] ? MINV : MAXV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      n_o <= '0;
      t_o <= '0;
    end else if (en) begin
      v_o <= v_i;
      n_o <= sat;
      t_o <= t_i;
    end
  end
endmodule

// File: rtl/aq_quant.sv
module aq_quant #(
  parameter int W   = 32,
  parameter int QSW = 16,
  parameter int QF  = 8,
  parameter int QW  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 v_i,
  input  logic signed [W-1:0]  n_i,
  input  logic [QSW-1:0]       qs_i,
  input  logic signed [QW-1:0] zp_i,
  output logic                 v_o,
  output logic signed [QW-1:0] q_o
);
  localparam int MW = W + QSW + 1;
  localparam logic signed [QW-1:0] QMAX = {1'b0, {(QW-1){1'b1}}};
  localparam logic signed [QW-1:0] QMIN = {1'b1, {(QW-1){1'b0}}};

  logic signed [MW-1:0] mul;
  logic signed [MW-1:0] shr;
  logic signed [MW-1:0] sum_q;
  logic [MW-QW:0]       top;
  logic signed [QW-1:0] clip;

  always_comb begin
    mul   = $signed({{(QSW+1){n_i[W-1]}}, n_i}) * $signed({{(W+1){1'b0}}, qs_i});
    shr   = mul >>> QF;
    sum_q = shr + $signed({{(MW-QW){zp_i[QW-1]}}, zp_i});
    top   = sum_q[MW-1:QW-1];
    if (top == '0 || top == '1) clip = sum_q[QW-1:0];
    else                        clip = sum_q[MW-1] ? QMIN : QMAX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      q_o <= '0;
    end else if (en) begin
      v_o <= v_i;
      q_o <= clip;
    end
  end
endmodule

// File: rtl/aq_l1.sv
module aq_l1 #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                v_i,
  input  logic signed [W-1:0] n_i,
  input  logic signed [W-1:0] t_i,
  output logic                v_o,
  output logic [W:0]          l_o
);
  logic signed [W:0] diff;
  logic [W:0]        mag;

  always_comb begin
    diff = $signed({n_i[W-1], n_i}) - $signed({t_i[W-1], t_i});
    mag  = diff[W] ? $unsigned(-diff) : $unsigned(diff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      l_o <= '0;
    end else if (en) begin
      v_o <= v_i;
      l_o <= mag;
    end
  end
endmodule

// File: rtl/act_quant_pipe.sv
module act_quant_pipe
  import act_quant_pkg::*;
#(
  parameter int ACC_W   = ACC_W_D,
  parameter int GAIN_W  = GAIN_W_D,
  parameter int SHIFT_W = SHIFT_W_D,
  parameter int QS_W    = QS_W_D,
  parameter int QFRAC   = QFRAC_D,
  parameter int QOUT_W  = QOUT_W_D
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [ACC_W-1:0]  in_data,
  input  logic signed [ACC_W-1:0]  in_target,
  input  logic [GAIN_W-1:0]        cfg_gain,
  input  logic [SHIFT_W-1:0]       cfg_shift,
  input  logic signed [ACC_W-1:0]  cfg_bias,
  input  logic [QS_W-1:0]          cfg_qscale,
  input  logic signed [QOUT_W-1:0] cfg_qzero,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic signed [QOUT_W-1:0] out_data,
  output logic                     out_loss_valid,
  output logic [ACC_W:0]           out_loss
);
  // One advance enable for every stage: a stall freezes the whole pipe (R9)
  logic adv;
  assign adv      = out_ready;
  assign in_ready = adv;

  logic                    r_v, n_v;
  logic signed [ACC_W-1:0] r_d, r_t, n_d, n_t;

  aq_relu #(.W(ACC_W)) relu_i (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(in_valid), .d_i(in_data), .t_i(in_target),
    .v_o(r_v), .d_o(r_d), .t_o(r_t)
  );

  aq_norm #(.W(ACC_W), .GW(GAIN_W), .SW(SHIFT_W)) norm_i (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(r_v), .d_i(r_d), .t_i(r_t),
    .gain_i(cfg_gain), .shift_i(cfg_shift), .bias_i(cfg_bias),
    .v_o(n_v), .n_o(n_d), .t_o(n_t)
  );

  aq_quant #(.W(ACC_W), .QSW(QS_W), .QF(QFRAC), .QW(QOUT_W)) quant_i (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(n_v), .n_i(n_d), .qs_i(cfg_qscale), .zp_i(cfg_qzero),
    .v_o(out_valid), .q_o(out_data)
  );

  aq_l1 #(.W(ACC_W)) loss_i (
    .clk(clk), .rst(rst), .en(adv),
    .v_i(n_v), .n_i(n_d), .t_i(n_t),
    .v_o(out_loss_valid), .l_o(out_loss)
  );
endmodule

// File: rtl/act_quant_pipe_chk.sv
module act_quant_pipe_chk #(
  parameter int QOUT_W = 8,
  parameter int LOSS_W = 33
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_ready,
  input logic              out_valid,
  input logic [QOUT_W-1:0] out_data,
  input logic              out_loss_valid,
  input logic [LOSS_W-1:0] out_loss
);
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1) &&
     !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)) |-> out_valid)
    else $error("p_latency_r7");

  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(out_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1) &&
     !$past(in_valid, 3)) |-> !out_valid)
    else $error("p_bubble_r7");

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_loss)))
    else $error("p_hold_r9");

  p_loss_pair_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_loss_valid && !$isunknown({out_data, out_loss})))
    else $error("p_loss_pair_r8");
endmodule

bind act_quant_pipe act_quant_pipe_chk #(.QOUT_W(QOUT_W), .LOSS_W(ACC_W + 1)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .out_loss_valid(out_loss_valid), .out_loss(out_loss)
);

// File: tb/act_quant_pipe_tb_top.sv
`timescale 1ns/1ps
module act_quant_pipe_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic signed [7:0] q;
    logic [32:0]       l;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [31:0] in_data = '0;
  logic signed [31:0] in_target = '0;
  logic [15:0]        gain_v = 16'd256;
  logic [5:0]         shift_v = 6'd8;
  logic signed [31:0] bias_v = '0;
  logic [15:0]        qs_v = 16'd256;
  logic signed [7:0]  zp_v = '0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic signed [7:0]  out_data;
  logic out_loss_valid;
  logic [32:0] out_loss;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t q_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  act_quant_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_target(in_target),
    .cfg_gain(gain_v), .cfg_shift(shift_v), .cfg_bias(bias_v),
    .cfg_qscale(qs_v), .cfg_qzero(zp_v),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_loss_valid(out_loss_valid), .out_loss(out_loss)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic signed [31:0] x, input logic signed [31:0] t,
                                output logic signed [7:0] q, output logic [32:0] l);
    longint r, n, m, d;
    r = (x < 0) ? 0 : longint'(x);
    n = ((r * longint'(gain_v)) >>> shift_v) + longint'(bias_v);
    if (n > 64'sd2147483647) n = 64'sd2147483647;
    if (n < -64'sd2147483648) n = -64'sd2147483648;
    m = ((n * longint'(qs_v)) >>> 8) + longint'(zp_v);
    if (m > 127) m = 127;
    if (m < -128) m = -128;
    q = m[7:0];
    d = n - longint'(t);
    if (d < 0) d = -d;
    l = d[32:0];
  endfunction

  // Scoreboard: compares every delivered result, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R9", "unexpected output", longint'(out_data), 0);
      end else begin
        exp_t e;
        e = q_exp.pop_front();
        check(out_data == e.q, e.tag, "int8 result", longint'(out_data), longint'(e.q));
        check(out_loss_valid && out_loss == e.l, e.tag, "R8 loss",
              longint'(out_loss), longint'(e.l));
      end
    end
  end

  task automatic push(input logic signed [31:0] x, input logic signed [31:0] t, input string tag);
    exp_t e;
    bit ok;
    in_valid = 1'b1; in_data = x; in_target = t;
    model(x, t, e.q, e.l);
    e.tag = tag;
    forever begin
      ok = in_ready;
      @(negedge clk); #1;
      if (ok) break;
    end
    q_exp.push_back(e);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (q_exp.size() != 0 && w < 60) begin
      @(negedge clk); #1; w++;
    end
    check(q_exp.size() == 0, tag, "pending results after drain", q_exp.size(), 0);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic [15:0] g, input logic [5:0] s, input logic signed [31:0] b,
                         input logic [15:0] qs, input logic signed [7:0] zp);
    gain_v = g; shift_v = s; bias_v = b; qs_v = qs; zp_v = zp;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R10", "out_valid after reset", out_valid, 0);
    check(!out_loss_valid, "R10", "out_loss_valid after reset", out_loss_valid, 0);
    check(out_data == 0, "R10", "out_data after reset", longint'(out_data), 0);
    check(out_loss == 0, "R10", "out_loss after reset", longint'(out_loss), 0);
    #1;
  endtask

  task automatic t_relu();
    set_cfg(16'd256, 6'd8, 0, 16'd256, 0);
    push(10, 7, "R1");
    push(-5, 3, "R1");
    push(0, 0, "R1");
    push(32'sh8000_0000, 0, "R1");
    push(100, 200, "R1");
    drain("R1");
  endtask

  task automatic t_gain_wide();
    set_cfg(16'hFFFF, 6'd16, 0, 16'd0, 0);
    push(32'sh7FFF_FFFF, 0, "R2");
    push(12345, 0, "R2");
    drain("R2");
    set_cfg(16'hFFFF, 6'd40, 0, 16'd256, 0);
    push(32'sh7FFF_FFFF, 0, "R2");
    drain("R2");
  endtask

  task automatic t_shift_bias();
    set_cfg(16'd3, 6'd1, -50, 16'd256, 0);
    push(7, 0, "R3");
    push(1000, -20, "R3");
    drain("R3");
    set_cfg(16'd5, 6'd2, -1000, 16'd32, 0);
    push(7, 5, "R3");
    push(400, 0, "R3");
    drain("R3");
  endtask

  task automatic t_norm_sat();
    set_cfg(16'd2, 6'd0, 32'sh7FFF_FFFF, 16'd1, 0);
    push(32'sh7FFF_FFFF, 32'sh8000_0000, "R4");
    drain("R4");
    set_cfg(16'd256, 6'd8, 32'sh8000_0000, 16'd1, 0);
    push(0, 0, "R4");
    drain("R4");
  endtask

  task automatic t_quant_floor();
    set_cfg(16'd256, 6'd8, -3, 16'd128, 8'sd5);
    push(-9, 0, "R5");
    push(1, 0, "R5");
    push(4, 0, "R5");
    drain("R5");
    set_cfg(16'd256, 6'd8, 0, 16'd384, -8'sd7);
    push(3, 1, "R5");
    push(21, 0, "R5");
    drain("R5");
  endtask

  task automatic t_clamp();
    set_cfg(16'd256, 6'd8, 0, 16'd256, 8'sd100);
    push(50, 0, "R6");
    push(27, 0, "R6");
    drain("R6");
    set_cfg(16'd256, 6'd8, -300, 16'd256, 0);
    push(0, 0, "R6");
    push(172, 0, "R6");
    drain("R6");
    set_cfg(16'd256, 6'd8, 0, 16'd256, -8'sd128);
    push(0, 0, "R6");
    push(255, 0, "R6");
    push(256, 0, "R6");
    drain("R6");
  endtask

  task automatic t_latency();
    exp_t e;
    int cnt = 0;
    set_cfg(16'd256, 6'd8, 0, 16'd256, 0);
    in_valid = 1'b1; in_data = 42; in_target = 40;
    model(42, 40, e.q, e.l);
    e.tag = "R7";
    q_exp.push_back(e);
    while (cnt < 10) begin
      @(negedge clk);
      cnt++;
      if (out_valid) break;
      #1 in_valid = 1'b0;
    end
    in_valid = 1'b0;
    check(cnt == 3, "R7", "edges from accept to out_valid", cnt, 3);
    drain("R7");
    for (int i = 0; i < 8; i++) push(i * 37 - 100, i, "R7");
    drain("R7");
    push(5, 0, "R7");
    @(negedge clk); #1;
    push(6, 0, "R7");
    drain("R7");
  endtask

  task automatic t_backpressure();
    set_cfg(16'd300, 6'd8, 7, 16'd200, -8'sd3);
    fork
      begin
        for (int i = 0; i < 10; i++) push(i * 11 + 1, 2 * i, "R9");
      end
      begin
        logic signed [7:0] hd;
        logic [32:0]       hl;
        repeat (4) @(negedge clk);
        #1 out_ready = 1'b0;
        @(negedge clk);
        hd = out_data; hl = out_loss;
        check(!in_ready, "R9", "in_ready during stall", in_ready, 0);
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          check(out_valid && out_data == hd, "R9", "held int8 during stall",
                longint'(out_data), longint'(hd));
          check(out_loss == hl, "R9", "held loss during stall",
                longint'(out_loss), longint'(hl));
        end
        #1 out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1 out_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1 out_ready = 1'b1;
      end
    join
    drain("R9");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_relu();
    t_gain_wide();
    t_shift_bias();
    t_norm_sat();
    t_quant_floor();
    t_clamp();
    t_latency();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule